// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits between a set of interrupt sources and one processor. It holds at most one pending interrupt, weighs it against the processor's current priority, and drives a single interrupt line. Sources offer work through a delivery stream. The block answers with a reject notification when an offer is refused or later displaced, and with an end-of-interrupt notification when the processor retires a source. It raises a resend pulse when it is again able to take work, so that sources can offer again whatever was refused earlier.

The processor uses a command port with five operations, selected by `cmd_op`: 0 sets the current priority from `cmd_data[7:0]`, 1 sets the inter-processor request priority from `cmd_data[7:0]`, 2 accepts, 3 ends an interrupt using the whole of `cmd_data`, and 4 polls. Other codes do nothing. The 32-bit interrupt word has the current priority in bits 31:24 and the pending source in bits 23:0. A source field of zero means the slot is empty. A lower priority value is more favoured, and 0xFF is the least favoured value. The inter-processor interrupt uses the reserved source number `IPI_SRC`, which defaults to 2.

The delivery stream is valid/ready. `dlv_ready` drops in any cycle where `cmd_valid` is high, and a delivery is taken only in a cycle where both `dlv_valid` and `dlv_ready` are high. A refused beat must be held until it is taken. Commands are always taken. Every output event is registered, so it appears in the cycle after the operation that caused it.

Top module: `ipc_presenter`

## Requirements
- R1: After reset, a poll returns interrupt word 0x00000000 and request priority 0xFF, `irq_out` is low, and an empty slot always holds pending priority 0xFF.
- R2: A delivery whose priority is strictly below the current priority is stored when the slot is empty. It is also stored when its priority is strictly below the pending priority. Once it is stored, `irq_out` is high, and `irq_out` stays high exactly while the slot is occupied.
- R3: A delivery whose priority is at or above the current priority is refused with a reject of its own source number. So is a delivery whose priority is at or above the priority already pending. A refused delivery leaves the state unchanged.
- R4: A delivery that displaces a pending source produces a reject carrying the displaced source number.
- R5: Accept returns the interrupt word as it stood before the accept, along with the request priority. It lowers `irq_out`, moves the pending priority into the current-priority field, and empties the slot.
- R6: A current-priority write that is below the old value, and at or below the pending priority, empties the slot, lowers `irq_out` and rejects the pending source. A lower write that stays above the pending priority keeps the slot.
- R7: A current-priority write at or above the old value with an empty slot pulses resend. If the request priority is then below the new current priority, the inter-processor source is presented in the same step.
- R8: A request-priority write below the current priority presents source `IPI_SRC` with that priority. If a pending source is at least as favoured, nothing changes. Otherwise the pending source is rejected first.
- R9: End-of-interrupt loads the current priority from `cmd_data[31:24]` and sends an end-of-interrupt notification for `cmd_data[23:0]`. If the slot is empty, it performs the resend of R7 using the new current priority.
- R10: Poll returns the interrupt word and the request priority and changes no state.
- R11: `dlv_ready` is low whenever `cmd_valid` is high, and a delivery offered in that cycle is neither stored nor rejected. Command codes 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command operand |
| dlv_valid | input | 1 | Delivery offered |
| dlv_ready | output | 1 | Delivery can be taken this cycle |
| dlv_src | input | 24 | Offered source number |
| dlv_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rsp_valid | output | 1 | Accept or poll result valid |
| rsp_word | output | 32 | Interrupt word result |
| rsp_ipi | output | 8 | Request priority result |
| rej_valid | output | 1 | Reject notification pulse |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt notification pulse |
| eoi_src | output | 24 | Retired source number |
| resend_valid | output | 1 | Resend request pulse |

## Verification
A corrupted slot appears on `irq_out` and in the next poll one cycle after the faulty step. A lost source number shows up as a reject carrying the wrong number, or as no reject at all. The bench follows a chain of operations in which each step depends on the state left by the step before. A fault in priority comparison or displacement therefore also alters the reject, end-of-interrupt and resend pulses expected several steps later. Edge cases include ties between equal priorities, a current-priority write that equals the old value, and an inter-processor request that arrives when a better source is already pending.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [2:0] {
    OP_SET_CUR = 3'd0,
    OP_SET_REQ = 3'd1,
    OP_ACCEPT  = 3'd2,
    OP_RETIRE  = 3'd3,
    OP_POLL    = 3'd4
  } ipc_op_e;

  typedef struct packed {
    logic [PRIO_W-1:0] cur;
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] pend;
    logic              line;
  } ipc_slot_t;
endpackage

// File: rtl/ipc_ipi_gate.sv
module ipc_ipi_gate
  import ipc_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  ipc_slot_t         slot_in,
  input  logic [PRIO_W-1:0] req_prio,
  output ipc_slot_t         slot_out,
  output logic              kick,
  output logic [SRC_W-1:0]  kick_src
);
  logic occupied;
  assign occupied = (slot_in.src != '0);

  always_comb begin
    slot_out = slot_in;
    kick     = 1'b0;
    kick_src = '0;
    if (!(occupied && (slot_in.pend <= req_prio))) begin
      kick          = occupied;
      kick_src      = slot_in.src;
      slot_out.src  = IPI_SRC;
      slot_out.pend = req_prio;
      slot_out.line = 1'b1;
    end
  end
endmodule

// File: rtl/ipc_step.sv
module ipc_step
  import ipc_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  ipc_slot_t          cur,
  input  logic [PRIO_W-1:0]  req,
  input  logic               cmd_fire,
  input  logic [2:0]         cmd_op,
  input  logic [WORD_W-1:0]  cmd_data,
  input  logic               dlv_fire,
  input  logic [SRC_W-1:0]   dlv_src,
  input  logic [PRIO_W-1:0]  dlv_prio,
  output ipc_slot_t          nxt,
  output logic [PRIO_W-1:0]  nxt_req,
  output logic               rej_fire,
  output logic [SRC_W-1:0]   rej_num,
  output logic               eoi_fire,
  output logic [SRC_W-1:0]   eoi_num,
  output logic               rsnd_fire,
  output logic               rsp_fire
);
  localparam int TOP_LO = SRC_W;

  logic [PRIO_W-1:0] lo_prio, hi_prio;
  logic              occupied;
  ipc_slot_t         g_in, g_out;
  logic [PRIO_W-1:0] g_prio;
  logic              g_kick;
  logic [SRC_W-1:0]  g_src;

  assign lo_prio  = cmd_data[PRIO_W-1:0];
  assign hi_prio  = cmd_data[WORD_W-1:TOP_LO];
  assign occupied = (cur.src != '0);

  always_comb begin
    g_in     = cur;
    g_in.cur = (cmd_op == OP_SET_CUR) ? lo_prio :
               (cmd_op == OP_RETIRE)  ? hi_prio : cur.cur;
    g_prio   = (cmd_op == OP_SET_REQ) ? lo_prio : req;
  end

  ipc_ipi_gate #(.IPI_SRC(IPI_SRC)) u_gate (
    .slot_in (g_in),
    .req_prio(g_prio),
    .slot_out(g_out),
    .kick    (g_kick),
    .kick_src(g_src)
  );

  always_comb begin
    nxt       = cur;
    nxt_req   = req;
    rej_fire  = 1'b0;
    rej_num   = '0;
    eoi_fire  = 1'b0;
    eoi_num   = '0;
    rsnd_fire = 1'b0;
    rsp_fire  = 1'b0;
    if (cmd_fire) begin
      case (cmd_op)
        OP_SET_CUR: begin
          nxt.cur = lo_prio;
          if (lo_prio < cur.cur) begin
            if (occupied && (lo_prio <= cur.pend)) begin
              nxt.src  = '0;
              nxt.pend = PRIO_NONE;
              nxt.line = 1'b0;
              rej_fire = 1'b1;
              rej_num  = cur.src;
            end
          end else if (!occupied) begin
            rsnd_fire = 1'b1;
            if (req < lo_prio) nxt = g_out;
          end
        end
        OP_SET_REQ: begin
          nxt_req = lo_prio;
          if (lo_prio < cur.cur) begin
            nxt      = g_out;
            rej_fire = g_kick;
            rej_num  = g_src;
          end
        end
        OP_ACCEPT: begin
          rsp_fire = 1'b1;
          nxt.cur  = cur.pend;
          nxt.src  = '0;
          nxt.pend = PRIO_NONE;
          nxt.line = 1'b0;
        end
        OP_RETIRE: begin
          nxt.cur  = hi_prio;
          eoi_fire = 1'b1;
          eoi_num  = cmd_data[SRC_W-1:0];
          if (!occupied) begin
            rsnd_fire = 1'b1;
            if (req < hi_prio) nxt = g_out;
          end
        end
        OP_POLL: rsp_fire = 1'b1;
        default: ;
      endcase
    end else if (dlv_fire) begin
      if ((dlv_prio >= cur.cur) || (occupied && (cur.pend <= dlv_prio))) begin
        rej_fire = 1'b1;
        rej_num  = dlv_src;
      end else begin
        rej_fire = occupied;
        rej_num  = cur.src;
        nxt.src  = dlv_src;
        nxt.pend = dlv_prio;
        nxt.line = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipc_presenter.sv
module ipc_presenter
  import ipc_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              dlv_valid,
  output logic              dlv_ready,
  input  logic [SRC_W-1:0]  dlv_src,
  input  logic [PRIO_W-1:0] dlv_prio,
  output logic              irq_out,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_word,
  output logic [PRIO_W-1:0] rsp_ipi,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_valid
);
  ipc_slot_t         st, st_nxt;
  logic [PRIO_W-1:0] req, req_nxt;
  logic              rej_f, eoi_f, rsnd_f, rsp_f;
  logic [SRC_W-1:0]  rej_n, eoi_n;

  assign dlv_ready = !cmd_valid;
  assign irq_out   = st.line;

  ipc_step #(.IPI_SRC(IPI_SRC)) u_step (
    .cur      (st),
    .req      (req),
    .cmd_fire (cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_data (cmd_data),
    .dlv_fire (dlv_valid && dlv_ready),
    .dlv_src  (dlv_src),
    .dlv_prio (dlv_prio),
    .nxt      (st_nxt),
    .nxt_req  (req_nxt),
    .rej_fire (rej_f),
    .rej_num  (rej_n),
    .eoi_fire (eoi_f),
    .eoi_num  (eoi_n),
    .rsnd_fire(rsnd_f),
    .rsp_fire (rsp_f)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st.cur       <= '0;
      st.src       <= '0;
      st.pend      <= PRIO_NONE;
      st.line      <= 1'b0;
      req          <= PRIO_NONE;
      rej_valid    <= 1'b0;
      rej_src      <= '0;
      eoi_valid    <= 1'b0;
      eoi_src      <= '0;
      resend_valid <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_word     <= '0;
      rsp_ipi      <= '0;
    end else begin
      st           <= st_nxt;
      req          <= req_nxt;
      rej_valid    <= rej_f;
      rej_src      <= rej_n;
      eoi_valid    <= eoi_f;
      eoi_src      <= eoi_n;
      resend_valid <= rsnd_f;
      rsp_valid    <= rsp_f;
      if (rsp_f) begin
        rsp_word <= {st.cur, st.src};
        rsp_ipi  <= req;
      end
    end
  end

  a_r1_empty_slot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st.src == '0) |-> (st.pend == PRIO_NONE));
  a_r2_line_tracks_slot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (st.src != '0));
  a_r5_accept_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACCEPT) |=> (!irq_out && rsp_valid));
  a_r8_ipi_fills_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET_REQ && cmd_data[PRIO_W-1:0] < st.cur) |=> (st.src != '0));
  a_r9_retire_notify: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RETIRE) |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));
  a_r10_poll_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_POLL) |=> ($stable(st) && $stable(req)));
  a_r11_cmd_blocks_dlv: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !dlv_ready);
endmodule

// File: tb/ipc_presenter_test.sv
module ipc_presenter_test;
  localparam int K_REJ = 0, K_EOI = 1, K_RSND = 2, K_RSP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        dlv_valid = 1'b0;
  logic        dlv_ready;
  logic [23:0] dlv_src = '0;
  logic [7:0]  dlv_prio = '0;
  logic        irq_out, rsp_valid, rej_valid, eoi_valid, resend_valid;
  logic [31:0] rsp_word;
  logic [7:0]  rsp_ipi;
  logic [23:0] rej_src, eoi_src;

  int          n_chk = 0, n_bad = 0;
  bit          run = 1'b0;
  int          q_kind[$];
  logic [39:0] q_val[$];
  string       q_req[$];

  always #5 clk = ~clk;

  ipc_presenter uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_src(dlv_src), .dlv_prio(dlv_prio), .irq_out(irq_out),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ipi(rsp_ipi),
    .rej_valid(rej_valid), .rej_src(rej_src), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src), .resend_valid(resend_valid)
  );

  task automatic push(int k, logic [39:0] v, string r);
    q_kind.push_back(k);
    q_val.push_back(v);
    q_req.push_back(r);
  endtask

  task automatic got(int k, logic [39:0] v);
    int ek;
    logic [39:0] ev;
    string er;
    n_chk++;
    if (q_kind.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: kind %0d value %h, expected none", k, v);
    end else begin
      ek = q_kind.pop_front();
      ev = q_val.pop_front();
      er = q_req.pop_front();
      if (ek != k || ev != v) begin
        n_bad++;
        $display("FAIL %s: got kind %0d value %h, expected kind %0d value %h", er, k, v, ek, ev);
      end
    end
  endtask

  always @(negedge clk) if (run) begin
    if (rej_valid)    got(K_REJ, {16'd0, rej_src});
    if (eoi_valid)    got(K_EOI, {16'd0, eoi_src});
    if (resend_valid) got(K_RSND, 40'd0);
    if (rsp_valid)    got(K_RSP, {rsp_ipi, rsp_word});
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h, expected %h", r, act, exp);
    end
  endtask

  task automatic do_cmd(logic [2:0] op, logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_dlv(logic [23:0] s, logic [7:0] p);
    @(negedge clk);
    dlv_valid = 1'b1; dlv_src = s; dlv_prio = p;
    @(negedge clk);
    dlv_valid = 1'b0;
  endtask

  task automatic poll(logic [31:0] w, logic [7:0] m, string r);
    push(K_RSP, {m, w}, r);
    do_cmd(3'd4, 32'd0);
  endtask

  task automatic finish_run();
    @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    while (q_kind.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s: missing event kind %0d value %h", q_req[0], q_kind[0], q_val[0]);
      void'(q_kind.pop_front()); void'(q_val.pop_front()); void'(q_req.pop_front());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    chk("R1 ready after reset", {31'd0, dlv_ready}, 32'd1);
    poll(32'h0000_0000, 8'hFF, "R1 reset poll");

    push(K_REJ, 40'd5, "R3 reject below current");
    do_dlv(24'd5, 8'd4);
    chk("R3 irq stays low", {31'd0, irq_out}, 32'd0);

    push(K_RSND, 40'd0, "R7 resend on lower favour");
    do_cmd(3'd0, 32'h10);
    push(K_RSND, 40'd0, "R7 resend on equal write");
    do_cmd(3'd0, 32'h10);

    do_dlv(24'd7, 8'd8);
    chk("R2 irq raised", {31'd0, irq_out}, 32'd1);
    poll(32'h1000_0007, 8'hFF, "R10 first poll");
    poll(32'h1000_0007, 8'hFF, "R10 repeat poll");

    push(K_REJ, 40'd9, "R3 reject tie with pending");
    do_dlv(24'd9, 8'd8);

    push(K_REJ, 40'd7, "R4 displaced source");
    do_dlv(24'd11, 8'd3);
    chk("R4 irq still high", {31'd0, irq_out}, 32'd1);

    do_cmd(3'd1, 32'h05);
    poll(32'h1000_000B, 8'h05, "R8 better pending kept");

    push(K_RSP, {8'h05, 32'h1000_000B}, "R5 accept result");
    do_cmd(3'd2, 32'd0);
    chk("R5 irq lowered", {31'd0, irq_out}, 32'd0);
    poll(32'h0300_0000, 8'h05, "R5 priority moved");

    push(K_EOI, 40'h0B, "R9 eoi source");
    push(K_RSND, 40'd0, "R9 resend after eoi");
    do_cmd(3'd3, 32'h1000_000B);
    chk("R9 ipi raised", {31'd0, irq_out}, 32'd1);
    poll(32'h1000_0002, 8'h05, "R9 ipi presented");

    push(K_REJ, 40'd2, "R6 clear pending");
    do_cmd(3'd0, 32'h04);
    chk("R6 irq lowered", {31'd0, irq_out}, 32'd0);
    poll(32'h0400_0000, 8'h05, "R6 slot empty");

    do_cmd(3'd1, 32'h01);
    poll(32'h0400_0002, 8'h01, "R8 ipi into empty slot");

    push(K_REJ, 40'd2, "R4 ipi displaced");
    do_dlv(24'h20, 8'd0);
    do_cmd(3'd1, 32'h00);
    do_cmd(3'd0, 32'h02);
    poll(32'h0200_0020, 8'h00, "R6 slot kept above pending");

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = '0;
    dlv_valid = 1'b1; dlv_src = 24'h33; dlv_prio = 8'd0;
    push(K_RSP, {8'h00, 32'h0200_0020}, "R11 poll during delivery");
    #1 chk("R11 ready low", {31'd0, dlv_ready}, 32'd0);
    @(negedge clk);
    cmd_valid = 1'b0; dlv_valid = 1'b0;
    poll(32'h0200_0020, 8'h00, "R11 delivery not taken");

    do_cmd(3'd7, 32'hFFFF_FFFF);
    poll(32'h0200_0020, 8'h00, "R11 unknown op ignored");

    push(K_RSP, {8'h00, 32'h0200_0020}, "R5 second accept");
    do_cmd(3'd2, 32'd0);
    push(K_EOI, 40'h20, "R9 eoi second");
    push(K_RSND, 40'd0, "R9 resend second");
    do_cmd(3'd3, 32'hFF00_0020);
    chk("R7 ipi on resend", {31'd0, irq_out}, 32'd1);
    poll(32'hFF00_0002, 8'h00, "R9 cur from top byte");

    finish_run();
  end
endmodule